// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. A programmable prescaler divides the input clock into a slow tick, typically one millisecond. While counting is enabled, a 16-bit tick count climbs from zero toward a programmed timeout. Software keeps the system alive by writing to a restart register, which clears the count. If the count reaches the timeout, the block raises a sticky expiry flag. When reset driving is enabled, it also pulses a one-cycle reset request toward the system reset generator.

Software reads the live count in the upper half of the timeout register. The remaining time is the timeout field minus the count field. A sequencer with four named states controls counting and expiry:

- `ST_OFF`: counting is disabled.
- `ST_RUN`: the count advances on each tick.
- `ST_FIRE`: a single cycle in which expiry is signalled.
- `ST_HOLD`: after expiry, the count is frozen until a restart.

The transitions are:

- Enable: `ST_OFF` to `ST_RUN`, when all three enable bits are set.
- Disable: from any other state to `ST_OFF`, when any enable bit is clear and no restart re-arms.
- Reach: `ST_RUN` to `ST_FIRE`, when count is greater than or equal to the timeout and there is no restart.
- Settle: `ST_FIRE` to `ST_HOLD`.
- Rearm: `ST_FIRE` or `ST_HOLD` to `ST_RUN`, on a restart write while enabled.

Top module: `wdog_timer`

## Requirements
- R1: Register map:
  - Offset 0x0 is control. Bits 17:0 hold the divide value, bit 18 is run, bit 21 is reset-drive enable, bit 24 is clock enable and bit 25 is prescaler enable. All other control bits read 0.
  - Offset 0x8 holds the timeout in bits 15:0 and reads the live count in bits 31:16.
  - Offset 0xC is restart and reads 0. Any other offset reads 0 and ignores writes.
- R2: After reset, every register reads zero, and `rst_req` and `expired` are low.
- R3: While enabled, a tick occurs once every max(divide value, 1) input clocks. The count starts from zero and rises by one per tick, and a count change is visible on the edge that ends the tick cycle.
- R4: The count advances only while bits 18, 24 and 25 are all set. If any of them is clear, the count holds its value.
- R5: The prescaler phase returns to zero whenever it is disabled. The first tick after enabling therefore lands exactly divide-value clocks after the enabling write.
- R6: When the count reaches the timeout while counting, the block raises `expired`. The count then holds at the timeout until a restart.
- R7: On expiry, `rst_req` is high for exactly one cycle, and only if bit 21 is set. It is never high with bit 21 clear.
- R8: Writes to the count field (bits 31:16 of offset 0x8) have no effect on the count.
- R9: A write of any value to offset 0xC clears the count to zero and resumes counting after expiry. A restart wins over a tick in the same cycle.
- R10: `expired` is sticky. It stays high across restarts and disables, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| expired | output | 1 | Sticky expiry flag |

## Verification
A corrupted count appears in bits 31:16 of the timeout register on the very next read, and it shows as a wrong step size or a wrong value after a known number of clocks. A sequencer stuck in the wrong state shows within one timeout period: either no hold at the timeout, a missing or doubled `rst_req`, or a count that keeps moving while disabled. A prescaler that keeps its phase across a disable shifts the first tick after enabling, and a read exactly three and four clocks later exposes it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control field positions (software decodes these)
    localparam int RUN_BIT    = 18;
    localparam int RSTEN_BIT  = 21;
    localparam int CLKEN_BIT  = 24;
    localparam int PREEN_BIT  = 25;

    // Count field position inside the timeout register
    localparam int CNT_SHIFT  = 16;

    // Register byte offsets
    localparam int OFF_CTRL    = 'h0;
    localparam int OFF_TMO     = 'h8;
    localparam int OFF_RESTART = 'hC;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2,
        ST_HOLD = 2'd3
    } wd_state_t;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int EXT_W = DIV_W + 1;

    logic [DIV_W-1:0] phase;
    logic             wrap;

    // A divide value of 0 or 1 yields a tick every clock.
    assign wrap = (EXT_W'(phase) + EXT_W'(1)) >= EXT_W'(div);
    assign tick = active && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!active || wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 18,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              run_o,
    output logic              rst_en_o,
    output logic              clk_en_o,
    output logic              pre_en_o,
    output logic [CNT_W-1:0]  timeout_o,
    output logic              restart_o
);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_TMO     = ADDR_W'(OFF_TMO);
    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFF_RESTART);

    logic wr_ctrl;
    logic wr_tmo;
    logic unused_wdata;

    assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
    assign wr_tmo    = bus_we && (bus_addr == A_TMO);
    assign restart_o = bus_we && (bus_addr == A_RESTART);

    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_o    <= '0;
            run_o    <= 1'b0;
            rst_en_o <= 1'b0;
            clk_en_o <= 1'b0;
            pre_en_o <= 1'b0;
        end else if (wr_ctrl) begin
            div_o    <= bus_wdata[DIV_W-1:0];
            run_o    <= bus_wdata[RUN_BIT];
            rst_en_o <= bus_wdata[RSTEN_BIT];
            clk_en_o <= bus_wdata[CLKEN_BIT];
            pre_en_o <= bus_wdata[PREEN_BIT];
        end
    end

    // Only the timeout half is writable; the count half is read-only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout_o <= '0;
        end else if (wr_tmo) begin
            timeout_o <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[DIV_W-1:0] = div_o;
            bus_rdata[RUN_BIT]   = run_o;
            bus_rdata[RSTEN_BIT] = rst_en_o;
            bus_rdata[CLKEN_BIT] = clk_en_o;
            bus_rdata[PREEN_BIT] = pre_en_o;
        end else if (bus_addr == A_TMO) begin
            bus_rdata[CNT_W-1:0]          = timeout_o;
            bus_rdata[CNT_SHIFT +: CNT_W] = cnt_i;
        end
    end

endmodule

// File: rtl/wdog_ctr.sv
module wdog_ctr
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic             restart,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] timeout,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req,
    output logic             expired
);
    wd_state_t state, state_nx;
    logic      reached;

    assign reached = (cnt >= timeout);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (cnt_en) state_nx = ST_RUN;                  // enable
            end
            ST_RUN: begin
                if (!cnt_en)                 state_nx = ST_OFF; // disable
                else if (!restart && reached) state_nx = ST_FIRE; // reach
            end
            ST_FIRE: begin
                if (!cnt_en)      state_nx = ST_OFF;             // disable
                else if (restart) state_nx = ST_RUN;             // rearm
                else              state_nx = ST_HOLD;            // settle
            end
            ST_HOLD: begin
                if (!cnt_en)      state_nx = ST_OFF;             // disable
                else if (restart) state_nx = ST_RUN;             // rearm
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        rst_req = 1'b0;
        unique case (state)
            ST_FIRE: rst_req = rst_en;
            ST_OFF, ST_RUN, ST_HOLD: rst_req = 1'b0;
            default: rst_req = 1'b0;
        endcase
    end

    // Tick count: restart wins, advance only while running below timeout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (state == ST_RUN && tick && !reached) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Sticky expiry flag, set on entry to ST_FIRE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expired <= 1'b0;
        end else if (state != ST_FIRE && state_nx == ST_FIRE) begin
            expired <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 18,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              expired
);
    logic [DIV_W-1:0] div_w;
    logic             run_w;
    logic             rst_en_w;
    logic             clk_en_w;
    logic             pre_en_w;
    logic [CNT_W-1:0] timeout_w;
    logic             restart_w;
    logic [CNT_W-1:0] cnt_w;
    logic             cnt_en_w;
    logic             tick_w;

    assign cnt_en_w = run_w && clk_en_w && pre_en_w;

    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_i(cnt_w),
        .div_o(div_w), .run_o(run_w), .rst_en_o(rst_en_w),
        .clk_en_o(clk_en_w), .pre_en_o(pre_en_w),
        .timeout_o(timeout_w), .restart_o(restart_w)
    );

    wdog_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .active(cnt_en_w), .div(div_w), .tick(tick_w)
    );

    wdog_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en_w), .tick(tick_w),
        .restart(restart_w), .rst_en(rst_en_w), .timeout(timeout_w),
        .cnt(cnt_w), .rst_req(rst_req), .expired(expired)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             expired,
    input logic             rst_en,
    input logic             cnt_en,
    input logic             restart,
    input logic [CNT_W-1:0] cnt
);
    // R7
    rst_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7
    rst_req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_en && expired));

    // R10
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);

    // R4
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !restart) |=> $stable(cnt));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($stable(cnt) || cnt == $past(cnt) + CNT_W'(1)));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .expired(expired),
    .rst_en(rst_en_w), .cnt_en(cnt_en_w), .restart(restart_w), .cnt(cnt_w)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        expired;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int dbl_pulse = 0;
    logic prev_req = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wdog_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .expired(expired)
    );

    always @(negedge clk) begin
        if (rst_req) begin
            pulses++;
            if (prev_req) dbl_pulse++;
        end
        prev_req = rst_req;
    end

    // {addr, write data, expected readback}
    localparam logic [67:0] VEC [0:6] = '{
        {4'h0, 32'hFFFB_FFFF, 32'h0323_FFFF},  // R1 control fields, spare bits 0
        {4'h0, 32'h0000_0000, 32'h0000_0000},  // R1
        {4'h0, 32'h0120_0005, 32'h0120_0005},  // R1
        {4'h8, 32'hABCD_1234, 32'h0000_1234},  // R8 count field ignored
        {4'h8, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R8 max timeout
        {4'hC, 32'h1234_5678, 32'h0000_0000},  // R1 restart reads 0
        {4'h4, 32'hFFFF_FFFF, 32'h0000_0000}   // R1 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, v2;
        int base;
        repeat (3) @(negedge clk);
        // R2 reset state
        rd(4'h0, v); check("R2", v, 32'h0);
        rd(4'h8, v); check("R2", v, 32'h0);
        rd(4'hC, v); check("R2", v, 32'h0);
        check("R2", {31'd0, rst_req}, 32'h0);
        check("R2", {31'd0, expired}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rd(VEC[i][67:64], v);
            check($sformatf("R1/R8 vec%0d", i), v, VEC[i][31:0]);
        end

        // R3 counting from zero, divide 4, timeout 10
        wr(4'h8, 32'h0000_000A);
        wr(4'h0, 32'h0304_0004);
        repeat (21) @(negedge clk);
        rd(4'h8, v); check("R3", v, 32'h0005_000A);

        // R6 expiry holds count, R7 no pulse without bit 21
        repeat (40) @(negedge clk);
        rd(4'h8, v); check("R6", v, 32'h000A_000A);
        check("R6", {31'd0, expired}, 32'h1);
        repeat (40) @(negedge clk);
        rd(4'h8, v); check("R6 hold", v, 32'h000A_000A);
        check("R7 none", pulses, 0);

        // R9 restart clears, R10 flag sticky
        wr(4'hC, 32'hDEAD_BEEF);
        rd(4'h8, v); check("R9", v, 32'h0000_000A);
        check("R10", {31'd0, expired}, 32'h1);

        // R4 run bit clear freezes count
        repeat (9) @(negedge clk);
        wr(4'h0, 32'h0300_0004);
        rd(4'h8, v);
        repeat (30) @(negedge clk);
        rd(4'h8, v2); check("R4 run", v2, v);

        // R5 prescaler phase restarts on enable
        wr(4'hC, 32'h0);
        wr(4'h0, 32'h0304_0004);
        repeat (3) @(negedge clk);
        rd(4'h8, v); check("R5 before", v, 32'h0000_000A);
        @(negedge clk);
        rd(4'h8, v); check("R5 tick", v, 32'h0001_000A);

        // R7 reset request, divide 1, timeout 3
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        wr(4'h8, 32'h3);
        base = pulses;
        wr(4'h0, 32'h0324_0001);
        repeat (20) @(negedge clk);
        check("R7 first", pulses - base, 1);
        wr(4'hC, 32'h0);
        repeat (20) @(negedge clk);
        check("R7 second", pulses - base, 2);
        check("R7 width", dbl_pulse, 0);

        // R3 divide 1 counts every clock; R9 restart beats tick
        wr(4'h8, 32'h0000_03E8);
        wr(4'hC, 32'h0);
        repeat (10) @(negedge clk);
        rd(4'h8, v); check("R3 div1", v, 32'h000A_03E8);
        wr(4'hC, 32'h0);
        rd(4'h8, v); check("R9 priority", v, 32'h0000_03E8);

        // R4 clock enable clear, then prescaler enable clear
        wr(4'h0, 32'h0224_0001);
        rd(4'h8, v);
        repeat (20) @(negedge clk);
        rd(4'h8, v2); check("R4 clk_en", v2, v);
        wr(4'h0, 32'h0324_0001);
        repeat (5) @(negedge clk);
        wr(4'h0, 32'h0124_0001);
        rd(4'h8, v);
        repeat (20) @(negedge clk);
        rd(4'h8, v2); check("R4 pre_en", v2, v);

        // R10 only reset clears the flag
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 reset", {31'd0, expired}, 32'h0);
        rst_n = 1'b1;
        rd(4'h0, v); check("R2 again", v, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule